// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received frame bytes from a byte stream into a ring of fixed-size receive buffers in memory. Each ring entry is a two-word descriptor. The first word holds the buffer address, a wrap marker and an ownership marker. The second word holds frame flags and the frame length. Before it fills a buffer, the block reads the descriptor's address word. It packs the bytes into 32-bit words and writes them to the buffer. It then writes the control word back, and after that the address word with the ownership marker set, so the buffer passes to software.

A frame longer than one buffer continues in the following descriptors. The first buffer of a frame is flagged as its start and the final buffer as its end. Only the end descriptor carries the frame length. An optional mode leaves out the trailing four check bytes, both from memory and from the length.

If a descriptor still belongs to software, the block raises a status bit and discards the rest of the frame. The descriptor pointer stays on that entry. A completed frame raises a sticky status bit that also drives the interrupt line. Software clears the status bits by writing ones to them. When the enable input is low, the block does no work and the pointer returns to the ring base.

Top module: `rx_ring_writer`

## Requirements
- R1: While reset is held and in the cycle after it, `s_ready`, `mem_req`, `irq` and both `rx_stat` bits are 0.
- R2: A buffer holds at most 128 bytes. Stored byte n of a buffer is at byte address buffer+n, in byte lane n mod 4 (bits 8*(n mod 4)+7 down to 8*(n mod 4)) of its little-endian word. Bytes beyond 128 continue in the next descriptor.
- R3: A descriptor's address word is at its base and its control word is at base+4. Before filling a buffer, the block reads the address word: buffer address in bits 31:2, wrap in bit 1, ownership (used) in bit 0. After the buffer is filled, the block writes the address word back with bit 0 set and bits 31:1 unchanged.
- R4: The control word has bit 14 set on the first buffer of a frame and bit 15 set on its last buffer. A frame that fits in one buffer has both bits set.
- R5: Control bits 11:0 hold the number of stored bytes of the whole frame in the end descriptor and 0 in every other descriptor. All other control bits are 0.
- R6: After a descriptor whose wrap bit is 1, the next descriptor used is at the ring base. Otherwise it is at the current descriptor address plus 8.
- R7: With `fcs_strip` at 1, the last four bytes of each frame are neither stored nor counted in the length.
- R8: If a fetched address word has bit 0 set, `rx_stat` bit 1 is set and that descriptor is not written. The rest of the frame is accepted and discarded. The next frame uses that same descriptor. Buffers already filled for the frame stay handed over with the start flag and no end flag.
- R9: After the end descriptor of a frame is written back, `rx_stat` bit 0 is set, and `irq` equals `rx_stat` bit 0.
- R10: A 1 on a bit of `stat_clr` clears the matching `rx_stat` bit in the next cycle. If a set and a clear of the same bit fall in the same cycle, the bit is set.
- R11: While `en` is 0, no byte is accepted and no memory request is made. The next frame after re-enable uses the descriptor at the ring base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low returns the pointer to the ring base |
| fcs_strip | input | 1 | Drop the last four bytes of every frame |
| ring_base | input | 32 | Byte address of the first descriptor |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Block accepts the stream byte this cycle |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with the acknowledge |
| mem_ack | input | 1 | Access completes in this cycle |
| stat_clr | input | 2 | Write-one-to-clear for the status bits |
| rx_stat | output | 2 | Bit 0 frame received, bit 1 owned descriptor met |
| irq | output | 1 | Interrupt, high while bit 0 of the status is set |

## Verification
The frame-received flag can be set by the final write-back and cleared by software in the same cycle. The bench provokes this by holding the clear for bit 0 high for the whole time a frame is stored. It then counts the cycles in which `irq` is high and expects exactly one: the set wins once, and the still-held clear removes it on the next edge. The bench also applies random memory stalls during the length sweeps, so that a word write and a descriptor write-back can be pending while the stream is stalled. The stored bytes and descriptors are then compared with values computed from the frame length alone.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int WORD_W       = 32;
    localparam int DESC_BYTES   = 8;
    localparam int CTL_OFFSET   = 4;
    localparam int ADR_USED_BIT = 0;
    localparam int ADR_WRAP_BIT = 1;
    localparam int CTL_SOF_BIT  = 14;
    localparam int CTL_EOF_BIT  = 15;
    localparam int CTL_LEN_W    = 12;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_FILL,
        S_WWORD,
        S_WCTL,
        S_WADR,
        S_DROP
    } wr_state_e;

    typedef struct packed {
        logic [29:0] base_w;
        logic        wrap;
        logic        used;
    } adr_word_t;

    function automatic logic [WORD_W-1:0] make_ctl(input logic sof,
                                                   input logic eof,
                                                   input logic [CTL_LEN_W-1:0] len);
        logic [WORD_W-1:0] w;
        w              = '0;
        w[CTL_SOF_BIT] = sof;
        w[CTL_EOF_BIT] = eof;
        if (eof) w[CTL_LEN_W-1:0] = len;
        return w;
    endfunction

endpackage

// File: rtl/rxr_delay.sv
module rxr_delay #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       push,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       full
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    tap [DEPTH];
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (push && cnt != CW'(DEPTH))
            cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            tap[0] <= din;
            for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
        end
    end

    assign dout = tap[DEPTH-1];
    assign full = (cnt == CW'(DEPTH));
endmodule

// File: rtl/rxr_pack.sv
module rxr_pack (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        we,
    input  logic [1:0]  lane,
    input  logic [7:0]  din,
    output logic [31:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            word <= '0;
        else if (we)
            word[lane*8 +: 8] <= din;
    end
endmodule

// File: rtl/rxr_status.sv
module rxr_status #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= set | (flags & ~clr);
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int BUF_BYTES = 128,
    parameter int FCS_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        fcs_strip,
    input  logic [31:0] ring_base,
    input  logic        s_valid,
    input  logic [7:0]  s_data,
    input  logic        s_last,
    output logic        s_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    input  logic [1:0]  stat_clr,
    output logic [1:0]  rx_stat,
    output logic        irq
);
    localparam int OFF_W  = $clog2(BUF_BYTES) + 1;
    localparam int WIDX_W = $clog2(BUF_BYTES / 4) + 1;

    wr_state_e            st;
    logic [31:0]          ptr;
    adr_word_t            cur;
    logic [OFF_W-1:0]     off;
    logic [WIDX_W-1:0]    widx;
    logic [CTL_LEN_W-1:0] len;
    logic                 first;
    logic                 fend;

    logic        acc, store, need_wr, strip_on, dly_full, pack_clr;
    logic [7:0]  dly_out, st_byte;
    logic [OFF_W-1:0] new_off;
    logic [31:0] word;
    logic        done_set, used_set;

    assign s_ready = en && (st == S_FILL || st == S_DROP);
    assign acc     = s_valid && s_ready;

    generate
        if (FCS_BYTES > 0) begin : g_strip
            rxr_delay #(.DEPTH(FCS_BYTES)) u_dly (
                .clk  (clk),
                .rst  (rst),
                .clr  (st == S_IDLE),
                .push (acc && st == S_FILL),
                .din  (s_data),
                .dout (dly_out),
                .full (dly_full)
            );
            assign strip_on = fcs_strip;
        end else begin : g_plain
            assign dly_out  = 8'h00;
            assign dly_full = 1'b0;
            assign strip_on = 1'b0;
        end
    endgenerate

    assign st_byte = strip_on ? dly_out : s_data;
    assign store   = acc && (st == S_FILL) && (strip_on ? dly_full : 1'b1);
    assign new_off = off + OFF_W'(store);
    assign need_wr = (store && new_off[1:0] == 2'b00) ||
                     (s_last && new_off[1:0] != 2'b00);

    assign pack_clr = (st == S_WWORD && mem_ack) || (st == S_IDLE);

    rxr_pack u_pack (
        .clk  (clk),
        .rst  (rst),
        .clr  (pack_clr),
        .we   (store),
        .lane (off[1:0]),
        .din  (st_byte),
        .word (word)
    );

    // Memory port requests
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = '0;
        unique case (st)
            S_FETCH: mem_req = 1'b1;
            S_WWORD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {cur.base_w, 2'b00} + 32'({widx, 2'b00});
                mem_wdata = word;
            end
            S_WCTL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr + 32'(CTL_OFFSET);
                mem_wdata = make_ctl(first, fend, len);
            end
            S_WADR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {cur.base_w, cur.wrap, 1'b1};
            end
            default: ;
        endcase
    end

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st    <= S_IDLE;
            ptr   <= ring_base;
            cur   <= '0;
            off   <= '0;
            widx  <= '0;
            len   <= '0;
            first <= 1'b1;
            fend  <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (s_valid) st <= S_FETCH;
                S_FETCH: if (mem_ack) begin
                    if (mem_rdata[ADR_USED_BIT]) begin
                        st <= S_DROP;
                    end else begin
                        cur  <= mem_rdata;
                        off  <= '0;
                        widx <= '0;
                        st   <= S_FILL;
                    end
                end
                S_FILL: if (acc) begin
                    off <= new_off;
                    len <= len + CTL_LEN_W'(store);
                    if (s_last) fend <= 1'b1;
                    st <= need_wr ? S_WWORD : (s_last ? S_WCTL : S_FILL);
                end
                S_WWORD: if (mem_ack) begin
                    widx <= widx + 1'b1;
                    st   <= (fend || off == OFF_W'(BUF_BYTES)) ? S_WCTL : S_FILL;
                end
                S_WCTL: if (mem_ack) st <= S_WADR;
                S_WADR: if (mem_ack) begin
                    ptr   <= cur.wrap ? ring_base : ptr + 32'(DESC_BYTES);
                    first <= 1'b0;
                    if (fend) begin
                        st    <= S_IDLE;
                        first <= 1'b1;
                        fend  <= 1'b0;
                        len   <= '0;
                    end else begin
                        st <= S_FETCH;
                    end
                end
                S_DROP: if (acc && s_last) begin
                    st    <= S_IDLE;
                    first <= 1'b1;
                    fend  <= 1'b0;
                    len   <= '0;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign done_set = (st == S_WADR) && mem_ack && fend && en;
    assign used_set = (st == S_FETCH) && mem_ack && mem_rdata[ADR_USED_BIT] && en;

    rxr_status #(.N(2)) u_stat (
        .clk   (clk),
        .rst   (rst),
        .set   ({used_set, done_set}),
        .clr   (stat_clr),
        .flags (rx_stat)
    );

    assign irq = rx_stat[0];
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic [1:0]  stat_clr,
    input logic [1:0]  rx_stat,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_rdata,
    input logic        set_done
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && en) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3

    AST_DONE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_stat[0]) |-> $past(mem_req && mem_we && mem_ack)); // R9

    AST_USED_FROM_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_stat[1]) |-> $past(mem_req && !mem_we && mem_ack && mem_rdata[0])); // R8

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rx_stat[0] && !stat_clr[0]) |=> rx_stat[0]); // R10

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rx_stat[0] && stat_clr[0] && !set_done) |=> !rx_stat[0]); // R10

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> !mem_req); // R11
endmodule

bind rx_ring_writer rx_ring_writer_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .stat_clr  (stat_clr),
    .rx_stat   (rx_stat),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .set_done  (done_set)
);

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;
    localparam int NDESC     = 4;
    localparam int BUF_BYTES = 128;
    localparam logic [31:0] RING_BASE = 32'h0000_0100;
    localparam logic [31:0] BUF_AREA  = 32'h0000_0400;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1, en = 1'b0, fcs_strip = 1'b0;
    logic        s_valid = 1'b0, s_last = 1'b0;
    logic [7:0]  s_data = 8'h00;
    logic        s_ready;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  stat_clr = 2'b00;
    logic [1:0]  rx_stat;
    logic        irq;

    rx_ring_writer i_rx_ring_writer (
        .clk(clk), .rst(rst), .en(en), .fcs_strip(fcs_strip), .ring_base(RING_BASE),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .stat_clr(stat_clr), .rx_stat(rx_stat), .irq(irq)
    );

    // Memory model with optional random stalls and a software write port
    logic [31:0] mem [0:1023];
    logic [7:0]  lfsr = 8'h5a;
    logic        stall_en = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_addr = '0, sw_data = '0;

    assign mem_ack   = mem_req && !(stall_en && lfsr[0]);
    assign mem_rdata = mem[mem_addr[11:2]];

    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (sw_we) mem[sw_addr[11:2]] <= sw_data;
        else if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
    end

    int n_chk = 0, n_bad = 0;
    int exp_idx = 0;
    int irq_cycles = 0;
    bit irq_mon = 1'b0;

    always @(negedge clk) if (irq_mon && irq) irq_cycles++;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, act=running exp=done");
        summary();
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem[a[11:2]];
    endfunction

    function automatic logic [7:0] rdb(input logic [31:0] a);
        logic [31:0] w;
        w = mem[a[11:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    function automatic logic [7:0] pat(input int len, input int i);
        return 8'((len * 5 + i * 3) & 255);
    endfunction

    function automatic logic [31:0] dsc(input int d);
        return RING_BASE + 32'(8 * d);
    endfunction

    function automatic logic [31:0] adr(input int d);
        return (BUF_AREA + 32'(BUF_BYTES * d)) | ((d == NDESC - 1) ? 32'h2 : 32'h0);
    endfunction

    task automatic sw_write(input logic [31:0] a, input logic [31:0] d);
        sw_we = 1'b1; sw_addr = a; sw_data = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic send_frame(input int len);
        for (int i = 0; i < len; i++) begin
            s_valid = 1'b1;
            s_data  = pat(len, i);
            s_last  = (i == len - 1);
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic wait_stat(input logic [1:0] m);
        int t;
        t = 0;
        while ((rx_stat & m) == 2'b00 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_stat();
        stat_clr = 2'b11;
        @(negedge clk);
        stat_clr = 2'b00;
        check(rx_stat == 2'b00, "R10 status clear", {30'd0, rx_stat}, 32'd0);
    endtask

    task automatic check_payload(input int d, input int len, input int from, input int n, input string req);
        bit ok;
        logic [7:0] a, e;
        ok = 1'b1; a = 8'h00; e = 8'h00;
        for (int j = 0; j < n; j++) begin
            if (ok && rdb(BUF_AREA + 32'(BUF_BYTES * d + j)) !== pat(len, from + j)) begin
                ok = 1'b0;
                a  = rdb(BUF_AREA + 32'(BUF_BYTES * d + j));
                e  = pat(len, from + j);
            end
        end
        check(ok, req, {24'd0, a}, {24'd0, e});
    endtask

    // Verify every buffer of a frame, then hand the descriptors back
    task automatic check_frame(input int len, input bit strip);
        int s, nb;
        s  = strip ? len - 4 : len;
        nb = (s == 0) ? 1 : (s + BUF_BYTES - 1) / BUF_BYTES;
        check(irq == 1'b1, "R9 irq after frame", {31'd0, irq}, 32'd1);
        for (int k = 0; k < nb; k++) begin
            int d, n;
            logic [31:0] ec;
            d  = (exp_idx + k) % NDESC;
            n  = (s - BUF_BYTES * k > BUF_BYTES) ? BUF_BYTES : s - BUF_BYTES * k;
            ec = ((k == 0) ? 32'h4000 : 32'h0) | ((k == nb - 1) ? (32'h8000 | 32'(s)) : 32'h0);
            check(rd(dsc(d)) === (adr(d) | 32'h1), "R3/R6 address word", rd(dsc(d)), adr(d) | 32'h1);
            check(rd(dsc(d) + 4) === ec, "R4/R5 control word", rd(dsc(d) + 4), ec);
            check_payload(d, len, BUF_BYTES * k, n, strip ? "R7 payload stripped" : "R2 payload");
            sw_write(dsc(d), adr(d));
            sw_write(dsc(d) + 4, 32'h0);
        end
        exp_idx = (exp_idx + nb) % NDESC;
        clear_stat();
    endtask

    task automatic run_frame(input int len, input bit strip);
        fcs_strip = strip;
        stall_en  = len[0];
        send_frame(len);
        wait_stat(2'b01);
        check_frame(len, strip);
    endtask

    initial begin
        // Reset state (R1)
        @(negedge clk);
        check(s_ready == 1'b0 && mem_req == 1'b0, "R1 idle ports in reset", {30'd0, s_ready, mem_req}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        check(rx_stat == 2'b00 && irq == 1'b0, "R1 status after reset", {29'd0, irq, rx_stat}, 32'd0);
        check(mem_req == 1'b0, "R1 no request after reset", {31'd0, mem_req}, 32'd0);

        for (int d = 0; d < NDESC; d++) begin
            sw_write(dsc(d), adr(d));
            sw_write(dsc(d) + 4, 32'h0);
        end
        en = 1'b1;
        @(negedge clk);

        // Length sweeps, plain (R2..R6, R9)
        for (int l = 1; l <= 140; l++) run_frame(l, 1'b0);
        for (int l = 250; l <= 260; l++) run_frame(l, 1'b0);
        for (int l = 380; l <= 400; l++) run_frame(l, 1'b0);
        run_frame(512, 1'b0);

        // Length sweeps with check bytes removed (R7)
        for (int l = 5; l <= 140; l++) run_frame(l, 1'b1);
        for (int l = 252; l <= 264; l++) run_frame(l, 1'b1);
        for (int l = 385; l <= 392; l++) run_frame(l, 1'b1);
        run_frame(516, 1'b1);
        fcs_strip = 1'b0;
        stall_en  = 1'b0;

        // Owned descriptor at frame start (R8)
        begin
            int d0;
            d0 = exp_idx;
            sw_write(dsc(d0), adr(d0) | 32'h1);
            send_frame(60);
            wait_stat(2'b10);
            check(rx_stat == 2'b10 && irq == 1'b0, "R8 status on owned entry", {29'd0, irq, rx_stat}, 32'h2);
            check(rd(dsc(d0) + 4) === 32'h0, "R8 owned entry untouched", rd(dsc(d0) + 4), 32'h0);
            check(rd(dsc(d0)) === (adr(d0) | 32'h1), "R8 owned address kept", rd(dsc(d0)), adr(d0) | 32'h1);
            clear_stat();
            sw_write(dsc(d0), adr(d0));
            run_frame(70, 1'b0);
        end

        // Owned descriptor in the middle of a frame (R8, R4)
        begin
            int d0, d1;
            d0 = exp_idx;
            d1 = (exp_idx + 1) % NDESC;
            sw_write(dsc(d1), adr(d1) | 32'h1);
            send_frame(200);
            wait_stat(2'b10);
            check(rx_stat == 2'b10, "R8 status mid frame", {30'd0, rx_stat}, 32'h2);
            check(rd(dsc(d0)) === (adr(d0) | 32'h1), "R8 first buffer handed over", rd(dsc(d0)), adr(d0) | 32'h1);
            check(rd(dsc(d0) + 4) === 32'h4000, "R4 start flag without end", rd(dsc(d0) + 4), 32'h4000);
            check_payload(d0, 200, 0, BUF_BYTES, "R8 first buffer payload");
            check(rd(dsc(d1) + 4) === 32'h0, "R8 owned entry untouched", rd(dsc(d1) + 4), 32'h0);
            sw_write(dsc(d0), adr(d0));
            sw_write(dsc(d0) + 4, 32'h0);
            sw_write(dsc(d1), adr(d1));
            clear_stat();
            exp_idx = d1;
            run_frame(50, 1'b0);
        end

        // Disable returns to ring base (R11)
        if (exp_idx == 0) run_frame(20, 1'b0);
        en = 1'b0;
        s_valid = 1'b1;
        s_data  = 8'hA5;
        repeat (3) @(negedge clk);
        check(s_ready == 1'b0 && mem_req == 1'b0, "R11 disabled is quiet", {30'd0, s_ready, mem_req}, 32'd0);
        s_valid = 1'b0;
        en = 1'b1;
        exp_idx = 0;
        @(negedge clk);
        run_frame(30, 1'b0);

        // Set and clear of the received flag in the same cycle (R10)
        irq_cycles = 0;
        irq_mon    = 1'b1;
        stat_clr   = 2'b01;
        send_frame(40);
        repeat (200) @(negedge clk);
        irq_mon  = 1'b0;
        stat_clr = 2'b00;
        check(irq_cycles == 1, "R10 set wins over clear", 32'(irq_cycles), 32'd1);
        @(negedge clk);
        check(rx_stat[0] == 1'b0, "R10 flag cleared afterwards", {31'd0, rx_stat[0]}, 32'd0);
        stat_clr = 2'b01;
        begin
            int d;
            d = exp_idx;
            check(rd(dsc(d) + 4) === (32'hC000 | 32'd40), "R5 length after race", rd(dsc(d) + 4), 32'hC000 | 32'd40);
        end
        stat_clr = 2'b00;

        summary();
    end
endmodule